// File: doc/BRIEF.md
# Page Protection Checker

This block watches every bus cycle of an 8/16-bit processor with a 24-bit address and decides whether the running process may make that access. Memory is split into 256-byte pages, and each page has an 8-bit protection code in a synchronous table. The top bit of a code allows writes and the low seven bits name the owning process. The block never changes or holds back the address; it only raises `abort` for a single clock in the cycle after a strobe whose access breaks the code. The surrounding logic can then throw away the data returned by memory.

Process 0 is the supervisor. It skips every check and is the only process that may reach the two reserved banks. Bank 0x7F exposes the protection table itself. Bank 0x80 holds the process-switch register and the fault record. Every abort puts the processor back in supervisor mode, so the abort handler can read the record and switch back to a user process. The table depth is a parameter. A full 16-bit page index needs `IDX_W = 16`. A smaller build indexes with the low `IDX_W` bits of the page number, so pages alias.

Top module: `page_guard`

## Requirements
- R1: After reset `abort` is low, the current process is 0, and the fault status byte reads 0.
- R2: A supervisor write in bank 0x7F (address bits [23:16]) stores `bus_wdata` as the code at index `bus_addr[IDX_W-1:0]`. A supervisor read there returns that code on `bus_rdata` in the cycle after the strobe. A checked access uses the code at index `bus_addr[IDX_W+7:8]`.
- R3: For a non-zero process, an access to an ordinary bank whose code bits [6:0] differ from the process number raises `abort` in the cycle after the strobe, for exactly that one cycle.
- R4: For a non-zero process, a write to a page it owns whose code bit 7 is 0 aborts. A read of that page, or a write when bit 7 is 1, does not abort.
- R5: While the current process is 0, no access raises `abort`.
- R6: A non-zero process touching bank 0x7F or 0x80 aborts. Its write there changes neither the table nor any register.
- R7: A supervisor write to bank 0x80 with `bus_addr[2:0]=0` sets the current process to `bus_wdata[6:0]`, starting with the next strobe. A supervisor read there returns the process number.
- R8: Every abort makes the current process 0 for all strobes after the faulting one.
- R9: In bank 0x80, offset 1 reads status: bit 7 set when a fault is recorded, bit 6 set when the recorded access was a write, and bits [1:0] holding the cause (1 owner mismatch, 2 write-protect, 3 reserved bank). The reserved-bank cause has priority over owner mismatch, which has priority over write-protect. Offsets 2, 3 and 4 read the fault address bytes [7:0], [15:8] and [23:16].
- R10: A recorded fault is held, and later faults do not overwrite it. A supervisor read of the status byte returns the record and then clears all of it to 0.
- R11: `bus_rdata` is 0 in any cycle not following a strobe, after writes, after an aborted access, after reads of ordinary banks, and after reads of bank 0x80 offsets 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 24 | Bus address |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data for the reserved banks, valid the cycle after the strobe |
| abort | output | 1 | One-cycle abort for the access strobed in the previous cycle |

## Verification
A corrupt process number appears at once as aborts on pages the process owns, or as missing aborts on foreign pages, on the very next strobe. A stale process register after an abort shows up on the next non-supervisor access. A fault record that is overwritten or not cleared appears in the status and address bytes the first time the supervisor reads them. A table write to the wrong index appears when the entry is read back, or on the first checked access to that page, in the cycle after its strobe.

// File: rtl/page_guard_pkg.sv
package page_guard_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_OWNER = 2'd1,
        CAUSE_WPROT = 2'd2,
        CAUSE_PRIV  = 2'd3
    } cause_e;

    localparam logic [2:0] OFF_PID  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam int         OFF_ADDR = 2;

endpackage

// File: rtl/page_guard_ram.sv
module page_guard_ram #(
    parameter int WIDTH = 8,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rd_q;

    // read-first single port: the read sees the word from before a same-edge write
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem_q[addr];
        end
        if (wr_en) begin
            mem_q[addr] <= wr_data;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/page_guard_judge.sv
module page_guard_judge
    import page_guard_pkg::*;
#(
    parameter int         ADDR_W   = 24,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] TBL_BANK = 8'h7F,
    parameter logic [7:0] CTL_BANK = 8'h80
) (
    input  logic              st_valid,
    input  logic              st_we,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-2:0] st_pid,
    input  logic [DATA_W-1:0] entry,
    output logic              fault,
    output cause_e            cause
);
    localparam int OWN_W = DATA_W - 1;

    logic [7:0] bank;
    logic       priv;

    always_comb begin
        bank  = st_addr[ADDR_W-1 -: 8];
        priv  = (bank == TBL_BANK) || (bank == CTL_BANK);
        cause = CAUSE_NONE;
        if (st_valid && (st_pid != '0)) begin
            if (priv) begin
                cause = CAUSE_PRIV;
            end else if (entry[OWN_W-1:0] != st_pid) begin
                cause = CAUSE_OWNER;
            end else if (st_we && !entry[DATA_W-1]) begin
                cause = CAUSE_WPROT;
            end
        end
        fault = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/page_guard_ctl.sv
module page_guard_ctl
    import page_guard_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pid,
    input  logic [DATA_W-2:0] wr_val,
    input  logic              fault,
    input  cause_e            cause,
    input  logic              st_we,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [2:0]        rd_off,
    input  logic              rd_clr,
    output logic [DATA_W-2:0] pid_eff,
    output logic [DATA_W-1:0] rd_byte
);
    localparam int OWN_W = DATA_W - 1;
    localparam int NBYTE = ADDR_W / DATA_W;

    typedef struct packed {
        logic [OWN_W-1:0]  pid;
        logic              fv;
        logic              fwe;
        cause_e            fc;
        logic [ADDR_W-1:0] fa;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        // an abort drops to the supervisor before the next strobe is taken
        pid_eff = fault ? '0 : ctl_q.pid;
        ctl_d.pid = wr_pid ? wr_val : pid_eff;
        if (fault && !ctl_q.fv) begin
            ctl_d.fv  = 1'b1;
            ctl_d.fwe = st_we;
            ctl_d.fc  = cause;
            ctl_d.fa  = st_addr;
        end else if (rd_clr) begin
            ctl_d.fv  = 1'b0;
            ctl_d.fwe = 1'b0;
            ctl_d.fc  = CAUSE_NONE;
            ctl_d.fa  = '0;
        end

        rd_byte = '0;
        if (rd_off == OFF_PID) begin
            rd_byte = {1'b0, ctl_q.pid};
        end else if (rd_off == OFF_STAT) begin
            rd_byte[DATA_W-1] = ctl_q.fv;
            rd_byte[DATA_W-2] = ctl_q.fwe;
            rd_byte[1:0]      = ctl_q.fc;
        end
        for (int k = 0; k < NBYTE; k++) begin
            if (32'(rd_off) == k + OFF_ADDR) begin
                rd_byte = ctl_q.fa[k*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{pid: '0, fv: 1'b0, fwe: 1'b0, fc: CAUSE_NONE, fa: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_PID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !wr_pid |=> ctl_q.pid == '0); // R8

    AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.fv && !rd_clr |=> ctl_q.fv && $stable(ctl_q.fa) && $stable(ctl_q.fc)); // R10
endmodule

// File: rtl/page_guard.sv
module page_guard
    import page_guard_pkg::*;
#(
    parameter int         ADDR_W   = 24,
    parameter int         DATA_W   = 8,
    parameter int         PAGE_W   = 8,
    parameter int         IDX_W    = 10,
    parameter logic [7:0] TBL_BANK = 8'h7F,
    parameter logic [7:0] CTL_BANK = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              abort
);
    localparam int OWN_W = DATA_W - 1;

    typedef struct packed {
        logic              v;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [OWN_W-1:0]  pid;
    } stage_t;

    stage_t st_d, st_q;

    logic [OWN_W-1:0]  pid_eff;
    logic [DATA_W-1:0] entry;
    logic [DATA_W-1:0] ctl_byte;
    logic [IDX_W-1:0]  ram_addr;
    logic              tbl_we;
    logic              wr_pid;
    logic              rd_clr;
    logic              fault;
    cause_e            cause;
    logic [7:0]        new_bank;
    logic [7:0]        st_bank;
    logic              st_super_rd;

    always_comb begin
        new_bank = bus_addr[ADDR_W-1 -: 8];
        st_bank  = st_q.addr[ADDR_W-1 -: 8];

        tbl_we   = bus_valid && bus_we && (pid_eff == '0) && (new_bank == TBL_BANK);
        wr_pid   = bus_valid && bus_we && (pid_eff == '0) && (new_bank == CTL_BANK)
                   && (bus_addr[2:0] == OFF_PID);
        ram_addr = (new_bank == TBL_BANK) ? bus_addr[IDX_W-1:0]
                                          : bus_addr[PAGE_W +: IDX_W];

        st_d.v    = bus_valid;
        st_d.we   = bus_we;
        st_d.addr = bus_addr;
        st_d.pid  = pid_eff;

        st_super_rd = st_q.v && !st_q.we && (st_q.pid == '0);
        rd_clr      = st_super_rd && (st_bank == CTL_BANK) && (st_q.addr[2:0] == OFF_STAT);

        bus_rdata = '0;
        if (st_super_rd && (st_bank == TBL_BANK)) begin
            bus_rdata = entry;
        end else if (st_super_rd && (st_bank == CTL_BANK)) begin
            bus_rdata = ctl_byte;
        end
        abort = fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{v: 1'b0, we: 1'b0, addr: '0, pid: '0};
        end else begin
            st_q <= st_d;
        end
    end

    page_guard_ram #(.WIDTH(DATA_W), .AW(IDX_W)) u_ram (
        .clk     (clk),
        .rd_en   (bus_valid),
        .wr_en   (tbl_we),
        .addr    (ram_addr),
        .wr_data (bus_wdata),
        .rd_data (entry)
    );

    page_guard_judge #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TBL_BANK(TBL_BANK), .CTL_BANK(CTL_BANK)
    ) u_judge (
        .st_valid (st_q.v),
        .st_we    (st_q.we),
        .st_addr  (st_q.addr),
        .st_pid   (st_q.pid),
        .entry    (entry),
        .fault    (fault),
        .cause    (cause)
    );

    page_guard_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_pid  (wr_pid),
        .wr_val  (bus_wdata[OWN_W-1:0]),
        .fault   (fault),
        .cause   (cause),
        .st_we   (st_q.we),
        .st_addr (st_q.addr),
        .rd_off  (st_q.addr[2:0]),
        .rd_clr  (rd_clr),
        .pid_eff (pid_eff),
        .rd_byte (ctl_byte)
    );

    AST_ABORT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(bus_valid)); // R3

    AST_SUPER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid) && ($past(pid_eff) == '0) |-> !abort); // R5

    AST_PRIV_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid) && ($past(pid_eff) != '0)
        && (($past(new_bank) == TBL_BANK) || ($past(new_bank) == CTL_BANK)) |-> abort); // R6

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_valid) |-> (bus_rdata == '0) && !abort); // R11
endmodule

// File: tb/page_guard_bench.sv
module page_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        abort;

    int checks = 0;
    int failures = 0;

    // bench model
    bit [7:0]  m_tbl [1024];
    bit [6:0]  m_pid;
    bit        m_fv, m_fwe;
    bit [1:0]  m_fc;
    bit [23:0] m_fa;

    always #2 clk = ~clk;

    page_guard u_page_guard (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .abort(abort)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [1:0] exp_cause(bit we, bit [23:0] a);
        bit [7:0] e;
        if (a[23:16] == 8'h7F || a[23:16] == 8'h80) return 2'd3;
        e = m_tbl[a[17:8]];
        if (e[6:0] != m_pid) return 2'd1;
        if (we && !e[7]) return 2'd2;
        return 2'd0;
    endfunction

    // called at a falling edge; checks the outputs one cycle later
    task automatic access(bit we, bit [23:0] a, bit [7:0] wd);
        bit [7:0] exp_rd = 8'h00;
        bit       exp_ab = 1'b0;
        string    tag_ab = "R5";
        string    tag_rd = "R11";
        bit [1:0] c;
        bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        if (m_pid == 0) begin
            if (a[23:16] == 8'h7F) begin
                if (we) m_tbl[a[9:0]] = wd;
                else begin exp_rd = m_tbl[a[9:0]]; tag_rd = "R2"; end
            end else if (a[23:16] == 8'h80) begin
                if (we) begin
                    if (a[2:0] == 3'd0) m_pid = wd[6:0];
                end else begin
                    case (a[2:0])
                        3'd0: begin exp_rd = {1'b0, m_pid}; tag_rd = "R7,R8"; end
                        3'd1: begin
                            exp_rd = {m_fv, m_fwe, 4'b0, m_fc}; tag_rd = "R9,R10";
                            m_fv = 0; m_fwe = 0; m_fc = 0; m_fa = 0;
                        end
                        3'd2: begin exp_rd = m_fa[7:0];   tag_rd = "R9"; end
                        3'd3: begin exp_rd = m_fa[15:8];  tag_rd = "R9"; end
                        3'd4: begin exp_rd = m_fa[23:16]; tag_rd = "R9"; end
                        default: exp_rd = 8'h00;
                    endcase
                end
            end
        end else begin
            c = exp_cause(we, a);
            tag_ab = (c == 2'd3) ? "R6" : (c == 2'd2) ? "R4" : "R3";
            if (c != 2'd0) begin
                exp_ab = 1'b1;
                if (!m_fv) begin m_fv = 1; m_fwe = we; m_fc = c; m_fa = a; end
                m_pid = 0;
            end
        end
        @(negedge clk);
        chk({tag_ab, " abort"}, {7'b0, abort}, {7'b0, exp_ab});
        chk({tag_rd, " rdata"}, bus_rdata, exp_rd);
    endtask

    task automatic idle();
        bus_valid = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        chk("R11 idle abort", {7'b0, abort}, 8'h00);
        chk("R11 idle rdata", bus_rdata, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset abort", {7'b0, abort}, 8'h00);
        chk("R1 reset rdata", bus_rdata, 8'h00);
        access(0, 24'h800000, 0);   // pid reads 0
        access(0, 24'h800001, 0);   // status reads 0
        chk("R1 pid after reset", {1'b0, m_pid}, 8'h00);

        // table setup: page0 owner1 writable, page1 owner1 read-only, page2 owner2
        access(1, 24'h7F0000, 8'h81);
        access(1, 24'h7F0001, 8'h01);
        access(1, 24'h7F0002, 8'h82);
        for (int p = 3; p < 16; p++)
            access(1, 24'h7F0000 | 24'(p), {1'($urandom), 7'(1 + $urandom % 3)});
        access(0, 24'h7F0001, 0);   // readback R2
        access(0, 24'h7F0002, 0);

        // R4 write-protect, R8 drop, R9 record, R10 clear-on-read
        access(1, 24'h800000, 8'h01);
        access(0, 24'h000010, 0);
        access(1, 24'h000020, 8'h55);
        access(0, 24'h000140, 0);   // read-only page read is fine
        access(1, 24'h000144, 8'h66); // write-protect fault
        access(0, 24'h800000, 0);
        access(0, 24'h800002, 0);
        access(0, 24'h800003, 0);
        access(0, 24'h800004, 0);
        access(0, 24'h800001, 0);
        access(0, 24'h800001, 0);   // cleared

        // R3 owner mismatch then R6 privileged, first fault kept (R10)
        access(1, 24'h800000, 8'h02);
        access(0, 24'h000008, 0);   // page0 owner1 -> fault
        access(1, 24'h800000, 8'h02);
        access(1, 24'h800000, 8'h05); // R6: ignored, fault
        access(0, 24'h800000, 0);   // pid 0, not 5
        access(1, 24'h800000, 8'h02);
        access(1, 24'h7F0002, 8'h00); // R6: table write ignored
        access(0, 24'h7F0002, 0);   // still 0x82
        access(0, 24'h800002, 0);
        access(0, 24'h800001, 0);   // owner cause, read access
        access(0, 24'h800005, 0);
        access(0, 24'h800007, 0);
        access(0, 24'h123456, 0);   // ordinary read: rdata 0
        idle();

        for (int i = 0; i < 600; i++) begin
            int r = $urandom % 10;
            bit [23:0] a = {12'h000, 4'($urandom), 8'($urandom)};
            if (r < 2 && m_pid == 0)
                access(1, 24'h800000, 8'($urandom % 4));
            else if (r < 2)
                access($urandom % 2, ($urandom % 2) ? 24'h7F0003 : 24'h800001, 8'($urandom));
            else if (r == 2 && m_pid == 0)
                access(0, 24'h800000 | 24'($urandom % 8), 0);
            else if (r == 3 && m_pid == 0)
                access(1, 24'h7F0000 | 24'($urandom % 16), {1'($urandom), 7'(1 + $urandom % 3)});
            else if (r == 4)
                idle();
            else if (r == 5 && m_pid == 0)
                access(0, 24'h7F0000 | 24'($urandom % 16), 0);
            else
                access($urandom % 2, a, 8'($urandom));
        end
        idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule